// File: doc/BRIEF.md
# Access Permission Checker

This block decides what a single memory access may do once its page descriptor has been found. It combines a 2-bit domain access value with a 2-bit permission code, the privilege of the requester and two global control bits, a system-protect bit and a ROM-protect bit. From these it produces the granted level: none, read-only or read/write. It then compares that level with the requested operation and raises a pass flag when the access may go ahead.

The domain value is a first gate. It can deny the access, grant full access without looking at the permission code, or hand the decision to the permission code. When the permission code is zero, the two control bits pick the outcome. Two combinations are illegal: the reserved domain value and both control bits set under permission code zero. Each of them gives no access and raises an error flag.

The result is registered. A request presented with `in_valid` appears on the outputs one clock later, qualified by `out_valid`. A two-state controller tracks whether the output register holds a result. The states are ST_EMPTY and ST_LOADED. The transitions are: ST_EMPTY to ST_LOADED on a valid request, ST_LOADED to ST_LOADED on a further valid request, ST_LOADED to ST_EMPTY on a cycle with no request, and ST_EMPTY to ST_EMPTY likewise. Reset sends the controller to ST_EMPTY.

Top module: `ap_checker`

## Requirements
- R1: Domain value 0 grants level none, with `out_pass`=0 and `out_err`=0, whatever the other inputs are.
- R2: Domain value 3 grants read/write with `out_err`=0 and ignores the permission code, privilege and control bits.
- R3: Domain value 2 is reserved: level none, `out_pass`=0, `out_err`=1.
- R4: Domain value 1 with permission code 1 grants read/write to privileged requests (`in_user`=0) and none to user requests.
- R5: Domain value 1 with permission code 2 grants read/write to privileged requests and read-only to user requests.
- R6: Domain value 1 with permission code 3 grants read/write to every requester.
- R7: Domain value 1 with permission code 0 behaves as follows. With `in_sys`=0 and `in_rom`=0 it grants none. With `in_sys`=1 and `in_rom`=0 it grants read-only when privileged and none for user requests. With `in_sys`=0 and `in_rom`=1 it grants read-only to every requester.
- R8: Domain value 1 with permission code 0 and both `in_sys` and `in_rom` set grants none and sets `out_err`=1.
- R9: Levels are encoded none=0, read-only=1, read/write=2 on `out_level`. `out_pass` is 1 exactly when the level is strictly greater than `in_write`, where a read is 0 and a write is 1.
- R10: `out_valid` equals `in_valid` delayed by one clock. `out_level`, `out_pass` and `out_err` change only after a cycle with `in_valid`=1, and otherwise hold their value.
- R11: A low `rst_n` sampled at a clock edge clears `out_valid`, `out_level`, `out_pass` and `out_err` to 0, even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is present this cycle |
| in_dav | input | 2 | Domain access value |
| in_ap | input | 2 | Permission code from the descriptor |
| in_user | input | 1 | 1 for a user-mode request, 0 for privileged |
| in_sys | input | 1 | System-protect control bit |
| in_rom | input | 1 | ROM-protect control bit |
| in_write | input | 1 | 1 for a write, 0 for a read |
| out_valid | output | 1 | Registered result is valid |
| out_level | output | 2 | Granted level (0 none, 1 read-only, 2 read/write) |
| out_pass | output | 1 | Access allowed |
| out_err | output | 1 | Reserved or unpredictable combination seen |

## Verification
The hardest cases to reach are the ones where an input must have no effect. These are the domain bypass values, where the permission code, privilege and control bits are ignored, and idle cycles, where the output register must hold its value. The stimulus sweeps all 256 combinations of domain, permission, privilege, control bits and direction, so every bypassed field is seen in each of its values. Idle cycles are placed between requests so that a held result differs from what the next request would produce. A reset is also applied in the middle of the run while `in_valid` is high.

// File: rtl/ap_checker_pkg.sv
package ap_checker_pkg;

    localparam int LVL_W = 2;
    localparam int DAV_W = 2;
    localparam int AP_W  = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_NONE = 2'd0,
        LVL_RO   = 2'd1,
        LVL_RW   = 2'd2,
        LVL_BAD  = 2'd3
    } level_t;

    typedef enum logic [1:0] {
        DOM_DENY     = 2'd0,
        DOM_CHECK    = 2'd1,
        DOM_RESERVED = 2'd2,
        DOM_OPEN     = 2'd3
    } dom_kind_t;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } hold_state_t;

endpackage

// File: rtl/ap_domain_gate.sv
module ap_domain_gate
    import ap_checker_pkg::*;
(
    input  logic [DAV_W-1:0] dav,
    output dom_kind_t        kind
);
    always_comb begin
        unique case (dav)
            2'd0:    kind = DOM_DENY;
            2'd1:    kind = DOM_CHECK;
            2'd2:    kind = DOM_RESERVED;
            default: kind = DOM_OPEN;
        endcase
    end
endmodule

// File: rtl/ap_perm_decode.sv
module ap_perm_decode
    import ap_checker_pkg::*;
(
    input  logic [AP_W-1:0] ap,
    input  logic            user,
    input  logic            sys,
    input  logic            rom,
    output level_t          level,
    output logic            unpred
);
    always_comb begin
        unpred = 1'b0;
        level  = LVL_NONE;
        unique case (ap)
            2'd0: begin
                unique case ({sys, rom})
                    2'b00: level = LVL_NONE;
                    2'b10: level = user ? LVL_NONE : LVL_RO;
                    2'b01: level = LVL_RO;
                    default: begin
                        level  = LVL_NONE;
                        unpred = 1'b1;
                    end
                endcase
            end
            2'd1:    level = user ? LVL_NONE : LVL_RW;
            2'd2:    level = user ? LVL_RO : LVL_RW;
            default: level = LVL_RW;
        endcase
    end
endmodule

// File: rtl/ap_verdict.sv
module ap_verdict
    import ap_checker_pkg::*;
(
    input  dom_kind_t kind,
    input  level_t    perm_level,
    input  logic      perm_unpred,
    input  logic      write,
    output level_t    level,
    output logic      pass,
    output logic      err
);
    always_comb begin
        unique case (kind)
            DOM_DENY: begin
                level = LVL_NONE;
                err   = 1'b0;
            end
            DOM_CHECK: begin
                level = perm_level;
                err   = perm_unpred;
            end
            DOM_RESERVED: begin
                level = LVL_NONE;
                err   = 1'b1;
            end
            default: begin
                level = LVL_RW;
                err   = 1'b0;
            end
        endcase
        pass = (level > level_t'({1'b0, write}));
    end
endmodule

// File: rtl/ap_checker.sv
module ap_checker
    import ap_checker_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DAV_W-1:0] in_dav,
    input  logic [AP_W-1:0]  in_ap,
    input  logic             in_user,
    input  logic             in_sys,
    input  logic             in_rom,
    input  logic             in_write,
    output logic             out_valid,
    output logic [LVL_W-1:0] out_level,
    output logic             out_pass,
    output logic             out_err
);
    dom_kind_t   kind;
    level_t      perm_level;
    logic        perm_unpred;
    level_t      nxt_level;
    logic        nxt_pass;
    logic        nxt_err;
    hold_state_t st, st_nxt;

    ap_domain_gate u_gate (
        .dav  (in_dav),
        .kind (kind)
    );

    ap_perm_decode u_perm (
        .ap     (in_ap),
        .user   (in_user),
        .sys    (in_sys),
        .rom    (in_rom),
        .level  (perm_level),
        .unpred (perm_unpred)
    );

    ap_verdict u_verdict (
        .kind        (kind),
        .perm_level  (perm_level),
        .perm_unpred (perm_unpred),
        .write       (in_write),
        .level       (nxt_level),
        .pass        (nxt_pass),
        .err         (nxt_err)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_EMPTY;
        else        st <= st_nxt;
    end

    always_comb begin
        unique case (st)
            ST_EMPTY:  st_nxt = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: st_nxt = in_valid ? ST_LOADED : ST_EMPTY;
            default:   st_nxt = ST_EMPTY;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_level <= LVL_NONE;
            out_pass  <= 1'b0;
            out_err   <= 1'b0;
        end else if (in_valid) begin
            out_level <= nxt_level;
            out_pass  <= nxt_pass;
            out_err   <= nxt_err;
        end
    end

    assign out_valid = (st == ST_LOADED);

    a_r1_domain_deny: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_dav == 2'd0 |=> out_level == LVL_NONE && !out_pass && !out_err);

    a_r2_domain_open: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_dav == 2'd3 |=> out_level == LVL_RW && !out_err);

    a_r3_domain_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_dav == 2'd2 |=> out_err && out_level == LVL_NONE && !out_pass);

    a_r8_unpredictable: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_dav == 2'd1 && in_ap == 2'd0 && in_sys && in_rom
        |=> out_err && out_level == LVL_NONE);

    a_r9_pass_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_pass |-> out_level != LVL_NONE);

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r10_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_level) && $stable(out_pass) && $stable(out_err));
endmodule

// File: tb/ap_checker_test.sv
module ap_checker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_dav = 2'd0;
    logic [1:0] in_ap = 2'd0;
    logic       in_user = 1'b0;
    logic       in_sys = 1'b0;
    logic       in_rom = 1'b0;
    logic       in_write = 1'b0;
    logic       out_valid;
    logic [1:0] out_level;
    logic       out_pass;
    logic       out_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state (what the outputs must show after the next edge)
    int    m_valid = 0;
    int    m_level = 0;
    int    m_pass  = 0;
    int    m_err   = 0;
    string m_tag   = "R11";

    always #5 clk = ~clk;

    ap_checker uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dav(in_dav),
        .in_ap(in_ap), .in_user(in_user), .in_sys(in_sys), .in_rom(in_rom),
        .in_write(in_write), .out_valid(out_valid), .out_level(out_level),
        .out_pass(out_pass), .out_err(out_err)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference for one request
    task automatic model(input int dav, input int ap, input int user, input int sys,
                         input int rom, input int wr,
                         output int lvl, output int err, output string tag);
        err = 0;
        if (dav == 0)      begin lvl = 0; tag = "R1"; end
        else if (dav == 3) begin lvl = 2; tag = "R2"; end
        else if (dav == 2) begin lvl = 0; err = 1; tag = "R3"; end
        else if (ap == 1)  begin lvl = user ? 0 : 2; tag = "R4"; end
        else if (ap == 2)  begin lvl = user ? 1 : 2; tag = "R5"; end
        else if (ap == 3)  begin lvl = 2; tag = "R6"; end
        else if (sys == 1 && rom == 1) begin lvl = 0; err = 1; tag = "R8"; end
        else begin
            tag = "R7";
            if (sys == 0 && rom == 0) lvl = 0;
            else if (sys == 1)        lvl = user ? 0 : 1;
            else                      lvl = 1;
        end
        if (wr != 0 && lvl == 0) tag = tag; // level 0 never passes
    endtask

    // Check last cycle's result, then drive a new cycle
    task automatic step(input bit rst, input bit v, input int pat);
        int lvl, err;
        string tag;
        @(negedge clk);
        cmp("R10", "out_valid", int'(out_valid), m_valid);
        cmp(m_tag, "out_level", int'(out_level), m_level);
        cmp("R9",  "out_pass",  int'(out_pass),  m_pass);
        cmp(m_tag, "out_err",   int'(out_err),   m_err);
        rst_n    = !rst;
        in_valid = v;
        in_dav   = pat[1:0];
        in_ap    = pat[3:2];
        in_user  = pat[4];
        in_sys   = pat[5];
        in_rom   = pat[6];
        in_write = pat[7];
        if (rst) begin
            m_valid = 0; m_level = 0; m_pass = 0; m_err = 0; m_tag = "R11";
        end else begin
            m_valid = v ? 1 : 0;
            if (v) begin
                model(pat & 3, (pat >> 2) & 3, (pat >> 4) & 1, (pat >> 5) & 1,
                      (pat >> 6) & 1, (pat >> 7) & 1, lvl, err, tag);
                m_level = lvl;
                m_err   = err;
                m_pass  = (lvl > ((pat >> 7) & 1)) ? 1 : 0;
                m_tag   = tag;
            end else begin
                m_tag = "R10";
            end
        end
    endtask

    initial begin
        // R11: reset with a request present
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'h0F);
        for (int p = 0; p < 256; p++) begin
            step(1'b0, 1'b1, p);
            if (p % 5 == 4) step(1'b0, 1'b0, (p * 37) & 255);
        end
        // back-to-back with held values, then mid-run reset (R11)
        step(1'b0, 1'b1, 8'h0F);
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h02);
        step(1'b1, 1'b1, 8'h0F);
        step(1'b0, 1'b0, 8'h0F);
        step(1'b0, 1'b1, 8'h86);
        step(1'b0, 1'b0, 8'h00);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule